// File: doc/BRIEF.md
# PCM voice serial port

A full-duplex serial port for telephony-grade voice samples. Each frame-sync period carries one slot (mono) or two back-to-back slots (stereo). A slot lasts 32 bit-clock periods. Each slot starts with a 16-bit sample sent most-significant bit first. The rest of the slot is filler: zero on the line going out, discarded on the line coming in. The frame-sync rate is the sample rate. It is set to 8 kHz for narrowband voice and 16 kHz for wideband voice.

In master operation the port derives its bit clock from the system clock with an integer half-period divider. It also emits a one-bit-wide frame sync every `frame_len` bit clocks. In slave operation it takes the bit clock and frame sync from outside, through two-flop synchronizers, and finds their edges in the system-clock domain. The system clock must then run at least four times faster than the bit clock.

The `edge_mode` input chooses between two conventions:
- At 0, transmit bits change on the rising bit-clock edge and sync is active high.
- At 1, transmit bits change on the falling edge and sync is active low.

Received bits are always sampled on the falling edge. Transmit samples enter through a one-deep buffer with a valid/ready handshake. Received samples leave with a one-cycle valid pulse.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is held: `ser_out` is 0, `tx_ready` is 1, `rx_valid` and `tx_underrun` are 0, `bclk_out` is 0, and `fsync_out` is at its inactive level (0 when `edge_mode`=0, 1 when `edge_mode`=1).
- R2: With `master`=1, `bclk_out` toggles every `half_div` system clocks. `fsync_out` is active for exactly one bit period, once every `frame_len` bit periods.
- R3: The first data bit of a frame is bit 15 of the slot's sample. It is sent in the bit period that begins at the launch edge where sync is seen active. Bits 14 down to 0 follow, and slot positions 16 to 31 are driven 0.
- R4: With `edge_mode`=0, `ser_out` changes only on rising bit-clock edges and sync is active high. With `edge_mode`=1, `ser_out` changes only on falling edges and sync is active low.
- R5: `ser_in` is sampled on falling bit-clock edges. The 16 data bits of a slot are assembled MSB first and presented on `rx_data` with a one-cycle `rx_valid` pulse. Bits in slot positions 16 to 31, and bits outside slots, never reach `rx_data`.
- R6: With `stereo`=1, a second slot occupies frame positions 32 to 63. It carries the next transmit sample and yields a second received sample. With `stereo`=0, only positions 0 to 31 form a slot.
- R7: At frame positions that lie outside every slot, `ser_out` is 0 until the next sync.
- R8: If no sample is buffered when a slot starts, the slot is sent as all zeros and `tx_underrun` pulses for one system cycle.
- R9: `tx_ready` is high exactly when the one-deep transmit buffer is empty. An accepted sample is sent in the next slot that starts, and `tx_ready` then returns high.
- R10: With `master`=0, timing follows `bclk_in`/`fsync_in`, `bclk_out` stays 0 and `fsync_out` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1: generate bit clock and sync; 0: follow external ones |
| edge_mode | input | 1 | 0: rising-edge launch, high sync; 1: falling-edge launch, low sync |
| stereo | input | 1 | 1: two slots per frame; 0: one slot |
| half_div | input | DIV_W | System clocks per bit-clock half period (master) |
| frame_len | input | FRM_W | Bit clocks per frame (master) |
| bclk_in | input | 1 | External bit clock (slave) |
| fsync_in | input | 1 | External frame sync (slave) |
| bclk_out | output | 1 | Generated bit clock |
| fsync_out | output | 1 | Generated frame sync |
| ser_out | output | 1 | Serial transmit data |
| ser_in | input | 1 | Serial receive data |
| tx_data | input | SAMPLE_W | Transmit sample |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_underrun | output | 1 | One-cycle pulse: slot started with no sample |
| rx_data | output | SAMPLE_W | Last received sample |
| rx_valid | output | 1 | One-cycle pulse: new received sample |

## Verification
The bench keeps the default parameters: 16-bit samples in 32-bit slots, an 8-bit divider and a 12-bit frame counter. It sets `half_div` to 6 and `frame_len` to 100 at run time, so a whole frame, including both slots and an idle tail, spans only about 1,200 system cycles. With frames that short, every combination of master or slave, rising or falling launch edge, and mono or stereo fits in the run. So do the underrun and buffer-hold cases. In slave runs the bench drives the serial line itself. It fills the padding positions with ones and patterns, so that discarded bits would show up in `rx_data` if the receiver kept them.

// File: rtl/pcm_voice_port.sv
`timescale 1ns/1ps
module pcm_voice_port #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  parameter int DIV_W    = 8,
  parameter int FRM_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master,
  input  logic                edge_mode,
  input  logic                stereo,
  input  logic [DIV_W-1:0]    half_div,
  input  logic [FRM_W-1:0]    frame_len,
  input  logic                bclk_in,
  input  logic                fsync_in,
  output logic                bclk_out,
  output logic                fsync_out,
  output logic                ser_out,
  input  logic                ser_in,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                tx_underrun,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);
  localparam int OFS_W = $clog2(SLOT_W);
  localparam int POS_W = OFS_W + 2;
  localparam logic [POS_W-1:0] POS_IDLE = '1;

  function automatic logic in_slot(input logic [POS_W-1:0] p, input logic st);
    return (p < POS_W'(SLOT_W)) || (st && p < POS_W'(2 * SLOT_W));
  endfunction

  function automatic logic is_data(input logic [POS_W-1:0] p);
    return {1'b0, p[OFS_W-1:0]} < (OFS_W + 1)'(SAMPLE_W);
  endfunction

  logic [2:0]          bc_s, di_s;
  logic [1:0]          fs_s;
  logic [DIV_W-1:0]    div_q;
  logic                bclk_q;
  logic [FRM_W-1:0]    fcnt_q;
  logic [POS_W-1:0]    pos_q;
  logic [SAMPLE_W-1:0] buf_q, sh_q, rx_sh_q, rx_data_q;
  logic                full_q, dx_q, und_q, rx_v_q;

  logic tick, rise_ev, fall_ev, launch, fs_end, fs_act, take, hs, rx_pick;
  logic [POS_W-1:0] pos_nx;

  assign tick    = master && (div_q == half_div - 1'b1);
  assign rise_ev = master ? (tick && !bclk_q) : (bc_s[1] && !bc_s[2]);
  assign fall_ev = master ? (tick &&  bclk_q) : (!bc_s[1] && bc_s[2]);
  assign launch  = edge_mode ? fall_ev : rise_ev;
  assign fs_end  = (fcnt_q == frame_len - 1'b1);
  assign fs_act  = master ? fs_end : (fs_s[1] ^ edge_mode);
  assign pos_nx  = fs_act ? '0 : ((pos_q == POS_IDLE) ? pos_q : pos_q + 1'b1);
  assign take    = launch && in_slot(pos_nx, stereo) && (pos_nx[OFS_W-1:0] == '0);
  assign hs      = tx_valid && !full_q;
  assign rx_pick = fall_ev && in_slot(pos_q, stereo) && is_data(pos_q);

  assign tx_ready    = !full_q;
  assign tx_underrun = und_q;
  assign ser_out     = dx_q;
  assign bclk_out    = bclk_q;
  assign fsync_out   = master ? (fs_end ^ edge_mode) : edge_mode;
  assign rx_data     = rx_data_q;
  assign rx_valid    = rx_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_s <= '0;
      di_s <= '0;
      fs_s <= '0;
    end else begin
      bc_s <= {bc_s[1:0], bclk_in};
      di_s <= {di_s[1:0], ser_in};
      fs_s <= {fs_s[0], fsync_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      fcnt_q <= '0;
    end else begin
      div_q  <= (!master || tick) ? '0 : div_q + 1'b1;
      bclk_q <= master ? (bclk_q ^ tick) : 1'b0;
      if (!master)
        fcnt_q <= '0;
      else if (launch)
        fcnt_q <= fs_end ? '0 : fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= POS_IDLE;
      buf_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      dx_q   <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      und_q  <= take && !full_q;
      full_q <= (full_q && !take) || hs;
      if (hs) buf_q <= tx_data;
      if (launch) begin
        pos_q <= pos_nx;
        if (take) begin
          dx_q <= full_q && buf_q[SAMPLE_W-1];
          sh_q <= full_q ? (buf_q << 1) : '0;
        end else if (in_slot(pos_nx, stereo) && is_data(pos_nx)) begin
          dx_q <= sh_q[SAMPLE_W-1];
          sh_q <= sh_q << 1;
        end else begin
          dx_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh_q   <= '0;
      rx_data_q <= '0;
      rx_v_q    <= 1'b0;
    end else begin
      rx_v_q <= 1'b0;
      if (rx_pick) begin
        rx_sh_q <= {rx_sh_q[SAMPLE_W-2:0], di_s[2]};
        if (pos_q[OFS_W-1:0] == OFS_W'(SAMPLE_W - 1)) begin
          rx_data_q <= {rx_sh_q[SAMPLE_W-2:0], di_s[2]};
          rx_v_q    <= 1'b1;
        end
      end
    end
  end

  a_r3_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot(pos_q, stereo) && !is_data(pos_q)) |-> !ser_out);
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_slot(pos_q, stereo) |-> !ser_out);
  a_r8_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_underrun);
  a_r5_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !bclk_out);
endmodule

// File: tb/tb_pcm_voice_port.sv
`timescale 1ns/1ps
module tb_pcm_voice_port;
  localparam int FL = 100;
  localparam int HB = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_mode = 0, cfg_stereo = 0;
  logic tb_bclk = 0, tb_fs = 0, tb_dr = 0;
  logic [15:0] tx_data = '0;
  logic tx_valid = 0;
  logic bclk_out, fsync_out, ser_out, tx_ready, tx_underrun, rx_valid;
  logic [15:0] rx_data;
  logic [63:0] dr_pat = '0;
  bit gen_on = 0, fs_prev = 0;
  int ph = 0;
  int n_chk = 0, n_bad = 0;
  int rx_n = 0, und_n = 0;
  logic [15:0] rx_log [0:255];
  bit rx_wide = 0, und_wide = 0, slave_bad = 0, rxv_prev = 0, und_prev = 0;

  wire bclk_w = cfg_master ? bclk_out : tb_bclk;
  wire fs_w   = cfg_master ? fsync_out : tb_fs;
  wire dr_w   = cfg_master ? ser_out : tb_dr;

  always #2.5 clk = ~clk;

  pcm_voice_port dut (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .edge_mode(cfg_mode),
    .stereo(cfg_stereo), .half_div(8'd6), .frame_len(12'(FL)),
    .bclk_in(tb_bclk), .fsync_in(tb_fs), .bclk_out(bclk_out),
    .fsync_out(fsync_out), .ser_out(ser_out), .ser_in(dr_w),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_underrun(tx_underrun), .rx_data(rx_data), .rx_valid(rx_valid));

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin rx_log[rx_n % 256] = rx_data; rx_n++; end
    if (tx_underrun) und_n++;
    if (rx_valid && rxv_prev) rx_wide = 1;
    if (tx_underrun && und_prev) und_wide = 1;
    rxv_prev = rx_valid;
    und_prev = tx_underrun;
    if (!cfg_master && (bclk_out || fsync_out != cfg_mode)) slave_bad = 1;
  end

  initial forever begin
    if (!gen_on) @(negedge clk);
    else begin
      ph = fs_prev ? 0 : (ph < 1000 ? ph + 1 : ph);
      tb_bclk = !cfg_mode;
      tb_dr = (ph < 64) ? dr_pat[63 - ph] : 1'b1;
      repeat (HB) @(negedge clk);
      tb_bclk = cfg_mode;
      fs_prev = (ph == FL - 1);
      tb_fs = fs_prev ^ cfg_mode;
      repeat (HB) @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic launch_edge();
    if (cfg_mode) @(negedge bclk_w); else @(posedge bclk_w);
  endtask

  task automatic opp_edge();
    if (cfg_mode) @(posedge bclk_w); else @(negedge bclk_w);
  endtask

  task automatic wait_frame(output int gap);
    bit a;
    gap = 0;
    do begin
      opp_edge(); #1;
      a = (fs_w != cfg_mode);
      launch_edge();
      gap++;
    end while (!a);
  endtask

  task automatic cap(output logic [95:0] v);
    v = '0;
    for (int k = 0; k < 96; k++) begin
      opp_edge(); #1;
      v[95 - k] = ser_out;
      launch_edge();
    end
  endtask

  function automatic logic [95:0] exp_frame(input logic [15:0] a, input logic [15:0] b, input logic st);
    logic [95:0] v = '0;
    v[95:80] = a;
    if (st) v[63:48] = b;
    return v;
  endfunction

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    tx_data = v; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic do_reset(input logic m, input logic md, input logic st);
    gen_on = 0;
    @(negedge clk);
    rst_n = 0;
    cfg_master = m; cfg_mode = md; cfg_stereo = st;
    tb_bclk = md; tb_fs = md; fs_prev = 0; ph = FL - 3;
    repeat (5) @(negedge clk);
    rst_n = 1;
    if (!m) gen_on = 1;
  endtask

  task automatic t_reset();
    gen_on = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    chk(ser_out === 0 && tx_ready === 1 && rx_valid === 0 && tx_underrun === 0
        && bclk_out === 0 && fsync_out === 0, "R1 reset outputs",
        {ser_out, tx_ready, rx_valid, tx_underrun, bclk_out, fsync_out}, 6'b010000);
  endtask

  task automatic t_master_mono();
    int g, u0, rb;
    realtime t1, t2;
    logic [95:0] v;
    do_reset(1, 0, 0);
    wait_frame(g);
    wait_frame(g);
    chk(g == FL, "R2 frame length (sync one bit wide)", 96'(g), 96'(FL));
    @(posedge bclk_out) t1 = $realtime;
    @(posedge bclk_out) t2 = $realtime;
    chk((t2 - t1) > 59.9 && (t2 - t1) < 60.1, "R2 bit clock period",
        96'(int'(t2 - t1)), 96'd60);
    push(16'hB38D);
    chk(tx_ready == 0, "R9 ready low while sample held", 96'(tx_ready), 96'd0);
    u0 = und_n;
    wait_frame(g);
    rb = rx_n;
    cap(v);
    chk(v == exp_frame(16'hB38D, 16'h0, 0), "R3/R4/R7 mono frame rise launch", v,
        exp_frame(16'hB38D, 16'h0, 0));
    chk(rx_n - rb == 1 && rx_log[rb % 256] == 16'hB38D, "R5 loopback receive",
        96'(rx_log[rb % 256]), 96'hB38D);
    chk(und_n == u0, "R8 no underrun with sample ready", 96'(und_n - u0), 96'd0);
    chk(tx_ready == 1, "R9 ready back after slot took sample", 96'(tx_ready), 96'd1);
  endtask

  task automatic t_master_stereo_fall();
    int g, u0, rb;
    logic [95:0] v;
    do_reset(1, 1, 1);
    wait_frame(g);
    wait_frame(g);
    chk(g == FL, "R4 low sync frame length", 96'(g), 96'(FL));
    repeat (70) launch_edge();
    u0 = und_n;
    rb = 0;
    fork
      begin push(16'h1E72); push(16'hC049); end
      begin wait_frame(g); rb = rx_n; cap(v); end
    join
    chk(v == exp_frame(16'h1E72, 16'hC049, 1), "R6/R4 stereo frame fall launch", v,
        exp_frame(16'h1E72, 16'hC049, 1));
    chk(rx_n - rb == 2 && rx_log[rb % 256] == 16'h1E72 && rx_log[(rb + 1) % 256] == 16'hC049,
        "R6 two received samples", {rx_log[rb % 256], rx_log[(rb + 1) % 256]}, 96'h1E72C049);
    chk(und_n == u0, "R8 no underrun in stereo frame", 96'(und_n - u0), 96'd0);
  endtask

  task automatic t_underrun();
    int g, u0;
    logic [95:0] v;
    do_reset(1, 0, 1);
    wait_frame(g);
    repeat (70) launch_edge();
    u0 = und_n;
    wait_frame(g);
    cap(v);
    chk(v == '0, "R8 underrun slots send zeros", v, 96'd0);
    chk(und_n - u0 == 2, "R8 one underrun per empty slot", 96'(und_n - u0), 96'd2);
    chk(!und_wide, "R8 underrun pulse one cycle", 96'(und_wide), 96'd0);
  endtask

  task automatic t_slave(input logic md, input logic st, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] w0, input logic [15:0] w1, input string tag);
    int g, rb;
    logic [95:0] v;
    dr_pat = {w0, 16'hFFFF, w1, 16'hA5A5};
    do_reset(0, md, st);
    wait_frame(g);
    repeat (70) launch_edge();
    rb = 0;
    fork
      begin push(a); if (st) push(b); end
      begin wait_frame(g); rb = rx_n; cap(v); end
    join
    chk(v == exp_frame(a, b, st), {tag, " R10 slave transmit frame"}, v, exp_frame(a, b, st));
    chk(rx_n - rb == (st ? 2 : 1), {tag, " R6 received sample count"},
        96'(rx_n - rb), 96'(st ? 2 : 1));
    chk(rx_log[rb % 256] == w0, {tag, " R5 padding ignored, first sample"},
        96'(rx_log[rb % 256]), 96'(w0));
    if (st)
      chk(rx_log[(rb + 1) % 256] == w1, {tag, " R5 second sample"},
          96'(rx_log[(rb + 1) % 256]), 96'(w1));
    chk(!slave_bad, {tag, " R10 master outputs quiet"}, 96'(slave_bad), 96'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master_mono();
    t_master_stereo_fall();
    t_underrun();
    t_slave(0, 1, 16'h6A13, 16'h9F04, 16'hD2C7, 16'h3B58, "rise stereo");
    t_slave(1, 0, 16'h8421, 16'h0000, 16'h47E9, 16'h1234, "fall mono");
    chk(!rx_wide, "R5 rx_valid pulse one cycle", 96'(rx_wide), 96'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule